// File: doc/BRIEF.md
# Pairwise Parallelism Dependence Checker

This block decides whether a small group of operations, given in program order, can execute concurrently. Each operation is described by two bitmasks over a shared space of variables or registers. One mask is the set of items the operation reads and the other is the set of items it writes. The block compares every pair of operations in a single cycle. For each pair it reports whether the pair may overlap in time, and if not, which kind of hazard blocks it. It also reports whether the whole group can run at once.

The requester drives the masks and a count of valid operations, then pulses `start_i`. On the next rising edge the block registers the per-pair hazard flags and raises `done_o`. The results stay stable until the next start pulse, even if the inputs change in the meantime. Operation k occupies bits `[k*MASK_W +: MASK_W]` of each mask bus. A lower index means an earlier operation.

Top module: `par_dep_checker`

## Requirements
- R1: While reset is asserted, and after it is released with no start pulse, `done_o` is 0, all hazard flags are 0, every bit of `pair_ok_o` is 1 and `group_ok_o` is 1.
- R2: When `start_i` is high at a rising edge, the inputs present at that edge are evaluated. From that edge on, `done_o` is 1 and the outputs reflect those inputs. `done_o` then stays 1 until reset.
- R3: For earlier operation e and later operation l (e < l), bit `e*NUM_OPS+l` of `flow_o` is 1 exactly when the write mask of e and the read mask of l share a set bit.
- R4: For e < l, bit `e*NUM_OPS+l` of `anti_o` is 1 exactly when the read mask of e and the write mask of l share a set bit.
- R5: For e < l, bit `e*NUM_OPS+l` of `outp_o` is 1 exactly when the write masks of e and l share a set bit.
- R6: Items that two operations only read never block the pair. Read-only sharing sets no flag.
- R7: Bit `r*NUM_OPS+c` of `pair_ok_o` is 1 when r equals c. Otherwise it is 1 exactly when none of the three flags is set for the pair (min(r,c), max(r,c)), so the matrix is symmetric. Flag bits where the column index is less than or equal to the row index are always 0.
- R8: `group_ok_o` is 1 exactly when every pair passes. A chain of passing pairs does not make the group pass if a non-adjacent pair fails.
- R9: Operations with index at or above `count_i` are ignored and treated as passing. A count above `NUM_OPS` means all operations are valid.
- R10: Without a start pulse, every output keeps its value while the mask and count inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Evaluate the current group on this edge |
| count_i | input | CNT_W | Number of valid operations, starting from index 0 |
| rd_masks_i | input | NUM_OPS*MASK_W | Read masks, operation k at bits k*MASK_W |
| wr_masks_i | input | NUM_OPS*MASK_W | Write masks, operation k at bits k*MASK_W |
| done_o | output | 1 | Results valid since the last start |
| flow_o | output | NUM_OPS*NUM_OPS | Flow hazard per pair, upper triangle |
| anti_o | output | NUM_OPS*NUM_OPS | Anti hazard per pair, upper triangle |
| outp_o | output | NUM_OPS*NUM_OPS | Output (write-write) hazard per pair, upper triangle |
| pair_ok_o | output | NUM_OPS*NUM_OPS | Symmetric may-run-together matrix |
| group_ok_o | output | 1 | Whole group may run together |

## Verification
The assertions check four things on every cycle. A start pulse must be followed by `done_o` and the flags must hold between starts. The lower triangle of the flag matrices must stay clear, and the group flag must agree with the pair matrix. Two further assertions check that a group of at most one operation passes, and that a pair sharing only read items passes. The correct direction of the flow and anti labels, the treatment of operations beyond the count, and the non-transitive group case can only be shown by the bench's vectors, which compare every flag against hand-worked results.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  // Hazard classification for one ordered pair (earlier, later)
  typedef struct packed {
    logic flow;  // later reads what earlier writes
    logic anti;  // later writes what earlier reads
    logic outp;  // both write a common item
  } dep_t;

endpackage

// File: rtl/pdc_pair_eval.sv
module pdc_pair_eval
  import pdc_pkg::*;
#(
  parameter int unsigned MASK_W = 16
) (
  input  logic [MASK_W-1:0] rd_early_i,
  input  logic [MASK_W-1:0] wr_early_i,
  input  logic [MASK_W-1:0] rd_late_i,
  input  logic [MASK_W-1:0] wr_late_i,
  input  logic              pair_valid_i,
  output dep_t              dep_o
);

  logic [MASK_W-1:0] raw_ovl;
  logic [MASK_W-1:0] war_ovl;
  logic [MASK_W-1:0] waw_ovl;

  // Read-read overlap is deliberately never formed
  always_comb begin
    raw_ovl = wr_early_i & rd_late_i;
    war_ovl = rd_early_i & wr_late_i;
    waw_ovl = wr_early_i & wr_late_i;
  end

  always_comb begin
    dep_o.flow = pair_valid_i & (|raw_ovl);
    dep_o.anti = pair_valid_i & (|war_ovl);
    dep_o.outp = pair_valid_i & (|waw_ovl);
  end

endmodule

// File: rtl/pdc_result_reg.sv
module pdc_result_reg #(
  parameter int unsigned MAT_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [MAT_W-1:0] flow_d_i,
  input  logic [MAT_W-1:0] anti_d_i,
  input  logic [MAT_W-1:0] outp_d_i,
  output logic [MAT_W-1:0] flow_q_o,
  output logic [MAT_W-1:0] anti_q_o,
  output logic [MAT_W-1:0] outp_q_o,
  output logic             done_o
);

  logic [MAT_W-1:0] flow_q, flow_n;
  logic [MAT_W-1:0] anti_q, anti_n;
  logic [MAT_W-1:0] outp_q, outp_n;
  logic             done_q, done_n;

  // Next-state: explicit enable on load
  always_comb begin
    flow_n = flow_q;
    anti_n = anti_q;
    outp_n = outp_q;
    done_n = done_q;
    if (load_i) begin
      flow_n = flow_d_i;
      anti_n = anti_d_i;
      outp_n = outp_d_i;
      done_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flow_q <= '0;
      anti_q <= '0;
      outp_q <= '0;
      done_q <= 1'b0;
    end else begin
      flow_q <= flow_n;
      anti_q <= anti_n;
      outp_q <= outp_n;
      done_q <= done_n;
    end
  end

  assign flow_q_o = flow_q;
  assign anti_q_o = anti_q;
  assign outp_q_o = outp_q;
  assign done_o   = done_q;

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q); // R2

  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(flow_q) && $stable(anti_q) && $stable(outp_q))); // R10

endmodule

// File: rtl/pdc_group_reduce.sv
module pdc_group_reduce #(
  parameter int unsigned NUM_OPS = 5,
  localparam int unsigned MAT_W = NUM_OPS * NUM_OPS
) (
  input  logic [MAT_W-1:0] flow_i,
  input  logic [MAT_W-1:0] anti_i,
  input  logic [MAT_W-1:0] outp_i,
  output logic [MAT_W-1:0] pair_ok_o,
  output logic             group_ok_o
);

  logic [MAT_W-1:0] dep_any;

  assign dep_any = flow_i | anti_i | outp_i;

  // Mirror the upper triangle into the lower; diagonal always passes
  for (genvar r = 0; r < NUM_OPS; r++) begin : g_row
    for (genvar c = 0; c < NUM_OPS; c++) begin : g_col
      if (r == c) begin : g_diag
        assign pair_ok_o[r*NUM_OPS+c] = 1'b1;
      end else if (r < c) begin : g_upper
        assign pair_ok_o[r*NUM_OPS+c] = ~dep_any[r*NUM_OPS+c];
      end else begin : g_lower
        assign pair_ok_o[r*NUM_OPS+c] = ~dep_any[c*NUM_OPS+r];
      end
    end
  end

  // Every pair must pass; no transitive shortcut
  assign group_ok_o = ~(|dep_any);

endmodule

// File: rtl/par_dep_checker.sv
module par_dep_checker
  import pdc_pkg::*;
#(
  parameter int unsigned NUM_OPS = 5,
  parameter int unsigned MASK_W  = 16,
  localparam int unsigned CNT_W  = $clog2(NUM_OPS + 1),
  localparam int unsigned MAT_W  = NUM_OPS * NUM_OPS,
  localparam int unsigned BUS_W  = NUM_OPS * MASK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [BUS_W-1:0] rd_masks_i,
  input  logic [BUS_W-1:0] wr_masks_i,
  output logic             done_o,
  output logic [MAT_W-1:0] flow_o,
  output logic [MAT_W-1:0] anti_o,
  output logic [MAT_W-1:0] outp_o,
  output logic [MAT_W-1:0] pair_ok_o,
  output logic             group_ok_o
);

  logic [CNT_W-1:0]   eff_cnt;
  logic [NUM_OPS-1:0] op_valid;
  logic [MAT_W-1:0]   flow_d, anti_d, outp_d;
  logic [MAT_W-1:0]   lower_mask;

  // Count saturates at the group size
  always_comb begin
    eff_cnt = (count_i > CNT_W'(NUM_OPS)) ? CNT_W'(NUM_OPS) : count_i;
  end

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_valid
    assign op_valid[k] = (CNT_W'(k) < eff_cnt);
  end

  // One evaluator per ordered pair in the upper triangle
  for (genvar e = 0; e < NUM_OPS; e++) begin : g_early
    for (genvar l = 0; l < NUM_OPS; l++) begin : g_late
      assign lower_mask[e*NUM_OPS+l] = (l <= e) ? 1'b1 : 1'b0;
      if (l > e) begin : g_pair
        dep_t dep;
        pdc_pair_eval #(.MASK_W(MASK_W)) u_pair (
          .rd_early_i   (rd_masks_i[e*MASK_W +: MASK_W]),
          .wr_early_i   (wr_masks_i[e*MASK_W +: MASK_W]),
          .rd_late_i    (rd_masks_i[l*MASK_W +: MASK_W]),
          .wr_late_i    (wr_masks_i[l*MASK_W +: MASK_W]),
          .pair_valid_i (op_valid[e] & op_valid[l]),
          .dep_o        (dep)
        );
        assign flow_d[e*NUM_OPS+l] = dep.flow;
        assign anti_d[e*NUM_OPS+l] = dep.anti;
        assign outp_d[e*NUM_OPS+l] = dep.outp;
      end else begin : g_none
        assign flow_d[e*NUM_OPS+l] = 1'b0;
        assign anti_d[e*NUM_OPS+l] = 1'b0;
        assign outp_d[e*NUM_OPS+l] = 1'b0;
      end
    end
  end

  pdc_result_reg #(.MAT_W(MAT_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (start_i),
    .flow_d_i (flow_d),
    .anti_d_i (anti_d),
    .outp_d_i (outp_d),
    .flow_q_o (flow_o),
    .anti_q_o (anti_o),
    .outp_q_o (outp_o),
    .done_o   (done_o)
  );

  pdc_group_reduce #(.NUM_OPS(NUM_OPS)) u_reduce (
    .flow_i     (flow_o),
    .anti_i     (anti_o),
    .outp_i     (outp_o),
    .pair_ok_o  (pair_ok_o),
    .group_ok_o (group_ok_o)
  );

  AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o); // R2

  AST_LOWER_TRI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((flow_o | anti_o | outp_o) & lower_mask) == '0); // R7

  AST_GROUP_MATCHES_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    group_ok_o == (&pair_ok_o)); // R8

  AST_READ_SHARE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (count_i >= CNT_W'(2))
     && ((wr_masks_i[0 +: MASK_W] & (rd_masks_i[MASK_W +: MASK_W] | wr_masks_i[MASK_W +: MASK_W])) == '0)
     && ((rd_masks_i[0 +: MASK_W] & wr_masks_i[MASK_W +: MASK_W]) == '0))
    |=> pair_ok_o[1]); // R6

  AST_SMALL_GROUP_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (count_i <= CNT_W'(1))) |=> group_ok_o); // R9

endmodule

// File: tb/tb_par_dep_checker.sv
module tb_par_dep_checker;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 5;
  localparam int W  = 16;
  localparam int MW = N * N;
  localparam int BW = N * W;

  typedef struct packed {
    logic [BW-1:0] rd;
    logic [BW-1:0] wr;
    logic [2:0]    cnt;
    logic          grp;
    logic [MW-1:0] fl;
    logic [MW-1:0] an;
    logic [MW-1:0] ou;
    logic [15:0]   tag; // two ASCII chars naming the requirement
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    // independent ops, each its own read and write item
    '{ {16'h1000,16'h0800,16'h0400,16'h0200,16'h0100},
       {16'h0010,16'h0008,16'h0004,16'h0002,16'h0001},
       3'd5, 1'b1, 25'h0, 25'h0, 25'h0, "R8" },
    // op0 writes item0, op2 reads it: flow pair(0,2) bit 2
    '{ {16'h0,16'h0,16'h0001,16'h0,16'h0}, {16'h0,16'h0,16'h0,16'h0,16'h0001},
       3'd5, 1'b0, 25'h4, 25'h0, 25'h0, "R3" },
    // op1 reads item3, op3 writes it: anti pair(1,3) bit 8
    '{ {16'h0,16'h0,16'h0,16'h0008,16'h0}, {16'h0,16'h0008,16'h0,16'h0,16'h0},
       3'd5, 1'b0, 25'h0, 25'h100, 25'h0, "R4" },
    // op0 and op4 write item5: output pair(0,4) bit 4
    '{ {BW{1'b0}}, {16'h0020,16'h0,16'h0,16'h0,16'h0020},
       3'd5, 1'b0, 25'h0, 25'h0, 25'h10, "R5" },
    // everyone reads item7 only
    '{ {16'h0080,16'h0080,16'h0080,16'h0080,16'h0080}, {BW{1'b0}},
       3'd5, 1'b1, 25'h0, 25'h0, 25'h0, "R6" },
    // 0||1 and 1||2 but 0 -> 2 flow: group fails
    '{ {16'h0,16'h0,16'h0002,16'h0004,16'h0001}, {16'h0,16'h0,16'h0,16'h0,16'h0002},
       3'd3, 1'b0, 25'h4, 25'h0, 25'h0, "R8" },
    // flow case but op2 beyond count 2
    '{ {16'h0,16'h0,16'h0001,16'h0,16'h0}, {16'h0,16'h0,16'h0,16'h0,16'h0001},
       3'd2, 1'b1, 25'h0, 25'h0, 25'h0, "R9" },
    // output case with count 7 saturating to 5
    '{ {BW{1'b0}}, {16'h0020,16'h0,16'h0,16'h0,16'h0020},
       3'd7, 1'b0, 25'h0, 25'h0, 25'h10, "R9" },
    // op1 and op2 both read and write item9: all three on pair(1,2) bit 7
    '{ {16'h0,16'h0,16'h0200,16'h0200,16'h0}, {16'h0,16'h0,16'h0200,16'h0200,16'h0},
       3'd5, 1'b0, 25'h80, 25'h80, 25'h80, "R7" },
    // output case with count 0
    '{ {BW{1'b0}}, {16'h0020,16'h0,16'h0,16'h0,16'h0020},
       3'd0, 1'b1, 25'h0, 25'h0, 25'h0, "R9" }
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [2:0]    cnt;
  logic [BW-1:0] rd, wr;
  logic          done, grp;
  logic [MW-1:0] fl, an, ou, ok;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  par_dep_checker #(.NUM_OPS(N), .MASK_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .count_i(cnt),
    .rd_masks_i(rd), .wr_masks_i(wr), .done_o(done),
    .flow_o(fl), .anti_o(an), .outp_o(ou), .pair_ok_o(ok), .group_ok_o(grp)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected matrix per R7, from expected flags
  function automatic logic [MW-1:0] ok_from(input logic [MW-1:0] f,
                                           input logic [MW-1:0] a,
                                           input logic [MW-1:0] o);
    logic [MW-1:0] res;
    logic [MW-1:0] dep;
    dep = f | a | o;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        if (r == c) res[r*N+c] = 1'b1;
        else if (r < c) res[r*N+c] = ~dep[r*N+c];
        else res[r*N+c] = ~dep[c*N+r];
    return res;
  endfunction

  task automatic run_vec(input vec_t v);
    string t;
    t = string'(v.tag);
    @(negedge clk);
    rd = v.rd; wr = v.wr; cnt = v.cnt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", {t, " done"}, 64'(done), 64'd1);
    chk("R3", {t, " flow"}, 64'(fl), 64'(v.fl));
    chk("R4", {t, " anti"}, 64'(an), 64'(v.an));
    chk("R5", {t, " outp"}, 64'(ou), 64'(v.ou));
    chk("R7", {t, " pair_ok"}, 64'(ok), 64'(ok_from(v.fl, v.an, v.ou)));
    chk("R8", {t, " group"}, 64'(grp), 64'(v.grp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cnt = '0; rd = '0; wr = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "done in reset", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "flags after reset", 64'(fl | an | ou), 64'd0);
    chk("R1", "pair_ok after reset", 64'(ok), 64'({MW{1'b1}}));
    chk("R1", "group after reset", 64'(grp), 64'd1);

    for (int v = 0; v < NV; v++) run_vec(VEC[v]);

    // R10: load the all-hazard vector, then change inputs without start
    run_vec(VEC[8]);
    @(negedge clk);
    rd = VEC[0].rd; wr = VEC[0].wr; cnt = 3'd5;
    repeat (3) @(negedge clk);
    chk("R10", "flow held", 64'(fl), 64'h80);
    chk("R10", "group held", 64'(grp), 64'd0);
    chk("R10", "done held", 64'(done), 64'd1);
    // R2: a new start replaces the held results
    run_vec(VEC[0]);

    // R1: reset again after activity
    run_vec(VEC[3]);
    rst_n = 1'b0;
    #1;
    chk("R1", "done on reset", 64'(done), 64'd0);
    chk("R1", "flags on reset", 64'(fl | an | ou), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule